// File: doc/BRIEF.md
# Word-to-Bit Transmit Serializer

This block turns a stream of parallel words from an upstream framer into one serial bit stream. The framer presents each word together with its own write clock and a valid strobe. The block registers the word on that clock and pushes it into a shallow dual-clock elastic FIFO. All read-side logic runs on a single fast bit clock. This covers the FIFO read, the word-to-bit shifter, the divide-by-word-width counter-clock and the final retiming flop.

The counter-clock goes back to the framer so that it can pace its writes at the word rate. After reset the read side stays idle until the FIFO is half full, which places the elastic margin in the middle of the buffer. From then on it takes one word each time the bit divider wraps. If the buffer is empty when a word is due, the last word is sent again and a sticky underflow flag is raised. A write that meets a full buffer is dropped and raises a sticky overflow flag in the write domain.

Top module: `tx_serializer`

## Requirements
- R1: A word enters the FIFO only when `wr_valid` is high at a rising edge of `wr_clk`. Data present while `wr_valid` is low never appears in the serial stream.
- R2: Each word is sent most significant bit first, one bit per `bit_clk` cycle. Its MSB drives `ser_out` in the bit period that follows the one in which `word_clk_out` rises. Its LSB drives `ser_out` in the bit period in which `word_clk_out` next rises.
- R3: `word_clk_out` has a period of 16 `bit_clk` cycles (the word width). It is high for 8 cycles and low for 8.
- R4: After reset the read side takes no word until the FIFO holds at least 4 words (half of the 8-entry depth). Until then `ser_out` stays low.
- R5: Words leave in the order they were written, none lost or duplicated, as long as the write and read rates match.
- R6: When a word is due and the FIFO is empty, the previous word is sent again and `udf_flag` goes high. It stays high until `bit_rst`. It is never set while data is available.
- R7: The FIFO holds 8 words. A write that finds it full is discarded, and `ovf_flag` goes high and stays high until `wr_rst`.
- R8: While `bit_rst` is high, `ser_out`, `word_clk_out` and `udf_flag` are low. While `wr_rst` is high, `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock supplied by the framer with the data |
| wr_rst | input | 1 | Synchronous reset of the write domain |
| wr_valid | input | 1 | Word on `wr_data` is to be written |
| wr_data | input | 16 | Parallel word from the framer |
| bit_clk | input | 1 | Fast serial bit clock |
| bit_rst | input | 1 | Synchronous reset of the bit-clock domain |
| ser_out | output | 1 | Retimed serial bit stream |
| word_clk_out | output | 1 | Bit clock divided by 16, returned to the framer |
| ovf_flag | output | 1 | Sticky overflow flag, write domain |
| udf_flag | output | 1 | Sticky underflow flag, bit-clock domain |

## Verification
The assertions rely on a few assumptions about the inputs. Each domain's reset is held for several cycles of its own clock before it is released. The two clocks keep a steady ratio, so the Gray-coded pointers are sampled cleanly. The read side never requests a word while the buffer looks empty. The stimulus runs the write clock at exactly 16 bit periods with a fixed phase offset, changes `wr_valid` and `wr_data` only on falling write-clock edges, and forces overflow and underflow on purpose by holding the read side in reset or by stopping writes.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    typedef enum logic {
        RD_FILL = 1'b0,
        RD_RUN  = 1'b1
    } rd_phase_t;

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/tx_ser_capture.sv
module tx_ser_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = vld_i;
        cap_d.dat = dat_i;
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign vld_o = cap_q.vld;
    assign dat_o = cap_q.dat;
endmodule

// File: rtl/tx_ser_sync2.sv
module tx_ser_sync2 #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) sy_q <= '0;
        else     sy_q <= sy_d;
    end

    assign q = sy_q.s2;
endmodule

// File: rtl/tx_ser_fifo.sv
module tx_ser_fifo
    import tx_ser_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_word,
    output logic          ovf_o,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    output logic [W-1:0]  rd_word,
    output logic [PW-1:0] rd_level,
    output logic          rd_empty
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ovf;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rside_t;

    logic [W-1:0]  mem_q [DEPTH];
    wside_t        w_d, w_q;
    rside_t        r_d, r_q;
    logic [PW-1:0] rgray_at_w, wgray_at_r;
    logic [PW-1:0] rbin_at_w, wbin_at_r;
    logic          full;

    tx_ser_sync2 #(.N(PW)) u_sync_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(r_q.gray), .q(rgray_at_w)
    );
    tx_ser_sync2 #(.N(PW)) u_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(w_q.gray), .q(wgray_at_r)
    );

    // write domain
    always_comb begin
        rbin_at_w = PW'(gray_to_bin(32'(rgray_at_w)));
        full      = (w_q.bin - rbin_at_w) == PW'(DEPTH);
        w_d       = w_q;
        if (wr_en) begin
            if (full) begin
                w_d.ovf = 1'b1;
            end else begin
                w_d.bin  = w_q.bin + 1'b1;
                w_d.gray = w_d.bin ^ (w_d.bin >> 1);
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) w_q <= '0;
        else        w_q <= w_d;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) mem_q[w_q.bin[AW-1:0]] <= wr_word;
    end

    // read domain
    always_comb begin
        wbin_at_r = PW'(gray_to_bin(32'(wgray_at_r)));
        rd_level  = wbin_at_r - r_q.bin;
        rd_empty  = (rd_level == '0);
        rd_word   = mem_q[r_q.bin[AW-1:0]];
        r_d       = r_q;
        r_d.bin   = r_q.bin + PW'(rd_en);
        r_d.gray  = r_d.bin ^ (r_d.bin >> 1);
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ovf_o = w_q.ovf;

    AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
        w_q.ovf |=> w_q.ovf); // R7
    AST_FULL_DROPS_WRITE: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && full) |=> $stable(w_q.bin)); // R7
    AST_READ_NEEDS_DATA: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_en |-> !rd_empty); // R6
    AST_GRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(w_q.gray ^ $past(w_q.gray)) <= 1); // R5
endmodule

// File: rtl/tx_ser_shift.sv
module tx_ser_shift
    import tx_ser_pkg::*;
#(
    parameter int W     = 16,
    parameter int PW    = 4,
    parameter int START = 4,
    parameter int CW    = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] level_i,
    input  logic          empty_i,
    input  logic [W-1:0]  word_i,
    output logic          rd_o,
    output logic          ser_o,
    output logic          cclk_o,
    output logic          udf_o
);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
    localparam logic [CW-1:0] HALF_CNT = CW'(W / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  sh;
        logic [W-1:0]  last;
        logic          ser;
        logic          cclk;
        rd_phase_t     phase;
        logic          udf;
    } sh_st_t;

    sh_st_t s_d, s_q;
    logic   wrap, go;

    always_comb begin
        s_d   = s_q;
        wrap  = (s_q.cnt == LAST_BIT);
        go    = (s_q.phase == RD_RUN) || (level_i >= PW'(START));
        rd_o  = wrap && go && !empty_i;
        s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        if (wrap) begin
            if (go) begin
                s_d.phase = RD_RUN;
                if (empty_i) begin
                    s_d.sh  = s_q.last;
                    s_d.udf = 1'b1;
                end else begin
                    s_d.sh   = word_i;
                    s_d.last = word_i;
                end
            end else begin
                s_d.sh = '0;
            end
        end else begin
            s_d.sh = s_q.sh << 1;
        end
        s_d.ser  = s_q.sh[W-1];
        s_d.cclk = (s_d.cnt < HALF_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ser_o  = s_q.ser;
    assign cclk_o = s_q.cclk;
    assign udf_o  = s_q.udf;

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        s_q.udf |=> s_q.udf); // R6
    AST_SHIFT_IN_WORD: assert property (@(posedge clk) disable iff (rst)
        (s_q.cnt != LAST_BIT) |=> (s_q.sh == ($past(s_q.sh) << 1))); // R2
    AST_FILL_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == RD_FILL) |=> !s_q.ser); // R4
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
    parameter int WORD_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int START_LVL  = FIFO_DEPTH / 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              bit_clk,
    input  logic              bit_rst,
    output logic              ser_out,
    output logic              word_clk_out,
    output logic              ovf_flag,
    output logic              udf_flag
);
    localparam int AW = $clog2(FIFO_DEPTH);
    localparam int PW = AW + 1;

    logic              cap_vld;
    logic [WORD_W-1:0] cap_dat;
    logic              rd_en;
    logic [WORD_W-1:0] rd_word;
    logic [PW-1:0]     rd_level;
    logic              rd_empty;

    tx_ser_capture #(.W(WORD_W)) u_cap (
        .clk(wr_clk), .rst(wr_rst),
        .vld_i(wr_valid), .dat_i(wr_data),
        .vld_o(cap_vld), .dat_o(cap_dat)
    );

    tx_ser_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .AW(AW), .PW(PW)) u_fifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(cap_vld), .wr_word(cap_dat),
        .ovf_o(ovf_flag),
        .rd_clk(bit_clk), .rd_rst(bit_rst), .rd_en(rd_en), .rd_word(rd_word),
        .rd_level(rd_level), .rd_empty(rd_empty)
    );

    tx_ser_shift #(.W(WORD_W), .PW(PW), .START(START_LVL)) u_shift (
        .clk(bit_clk), .rst(bit_rst),
        .level_i(rd_level), .empty_i(rd_empty), .word_i(rd_word),
        .rd_o(rd_en), .ser_o(ser_out), .cclk_o(word_clk_out), .udf_o(udf_flag)
    );
endmodule

// File: tb/tx_serializer_tb.sv
module tx_serializer_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int WCLK_PERIOD = CLK_PERIOD * 16;
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        16'h8000, 16'h0001, 16'hA5A5, 16'h5A5A, 16'hFFFF, 16'h1234,
        16'h8001, 16'h7FFE, 16'h0F0F, 16'hC3C3, 16'h0100, 16'hBEEF
    };

    logic        wr_clk = 1'b0, bit_clk = 1'b0;
    logic        wr_rst = 1'b1, bit_rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        ser_out, word_clk_out, ovf_flag, udf_flag;

    int total = 0, bad = 0;
    bit done = 0;

    logic [15:0] rx_w [512];
    logic        rx_u [512];
    int          rx_g [512];
    int          rx_h [512];
    int          rx_n = 0;
    logic [15:0] sr = '0;
    logic        cclk_prev = 1'b0;
    int          since = 0, highs = 0;

    tx_serializer u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .bit_clk(bit_clk), .bit_rst(bit_rst),
        .ser_out(ser_out), .word_clk_out(word_clk_out),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;
    initial begin
        #37;
        forever #(WCLK_PERIOD/2) wr_clk = ~wr_clk;
    end

    // word collector: a word is complete when the counter-clock rises
    always @(negedge bit_clk) begin
        sr = {sr[14:0], ser_out};
        if (word_clk_out && !cclk_prev) begin
            if (rx_n < 512) begin
                rx_w[rx_n] = sr;
                rx_u[rx_n] = udf_flag;
                rx_g[rx_n] = since;
                rx_h[rx_n] = highs;
                rx_n++;
            end
            since = 1;
            highs = 1;
        end else begin
            since++;
            highs += int'(word_clk_out);
        end
        cclk_prev = word_clk_out;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_words(input int from, input int n);
        for (int i = from; i < from + n; i++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            wr_data  = VEC[i];
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
        wr_data  = 16'hDEAD;
    endtask

    function automatic int first_nonzero();
        for (int i = 0; i < rx_n; i++) if (rx_w[i] != 16'h0) return i;
        return -1;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int f;
        int nz;
        // reset state, R8
        repeat (3) @(posedge wr_clk);
        @(negedge bit_clk);
        chk("R8 ser low in reset", {15'b0, ser_out}, 16'h0);
        chk("R8 cclk low in reset", {15'b0, word_clk_out}, 16'h0);
        chk("R8 udf low in reset", {15'b0, udf_flag}, 16'h0);
        chk("R8 ovf low in reset", {15'b0, ovf_flag}, 16'h0);

        // stream test: threshold, order, underflow
        @(negedge wr_clk); wr_rst = 1'b0;
        @(negedge bit_clk); bit_rst = 1'b0;
        rx_n = 0;
        put_words(0, 3);
        repeat (30 * 16) @(negedge bit_clk);
        nz = 0;
        for (int i = 0; i < rx_n; i++) if (rx_w[i] != 16'h0) nz++;
        chk("R4 no word below half level", 16'(nz), 16'h0);
        chk("R4 no underflow while filling", {15'b0, udf_flag}, 16'h0);
        put_words(3, NV - 3);
        repeat (20 * 16) @(negedge bit_clk);
        f = first_nonzero();
        chk("R4 stream started", {15'b0, f >= 0}, 16'h1);
        if (f >= 0) begin
            for (int i = 0; i < NV; i++) begin
                chk($sformatf("R1 R2 R5 word %0d", i), rx_w[f+i], VEC[i]);
            end
            chk("R3 counter-clock period", 16'(rx_g[f+5]), 16'd16);
            chk("R3 counter-clock high time", 16'(rx_h[f+5]), 16'd8);
            chk("R6 no underflow with data", {15'b0, rx_u[f+10]}, 16'h0);
            chk("R6 repeat last word", rx_w[f+NV], VEC[NV-1]);
            chk("R6 repeat again", rx_w[f+NV+1], VEC[NV-1]);
        end
        chk("R6 underflow sticky", {15'b0, udf_flag}, 16'h1);

        // overflow test
        @(negedge wr_clk); wr_rst = 1'b1;
        @(negedge bit_clk); bit_rst = 1'b1;
        repeat (3) @(negedge wr_clk);
        wr_rst = 1'b0;
        put_words(0, 10);
        repeat (3) @(negedge wr_clk);
        chk("R7 overflow flag", {15'b0, ovf_flag}, 16'h1);
        rx_n = 0;
        @(negedge bit_clk); bit_rst = 1'b0;
        repeat (20 * 16) @(negedge bit_clk);
        f = first_nonzero();
        chk("R7 drain started", {15'b0, f >= 0}, 16'h1);
        if (f >= 0) begin
            for (int i = 0; i < 8; i++) begin
                chk($sformatf("R7 kept word %0d", i), rx_w[f+i], VEC[i]);
            end
            chk("R7 dropped writes absent", rx_w[f+8], VEC[7]);
        end
        chk("R7 overflow still set", {15'b0, ovf_flag}, 16'h1);

        // reset mid-run, R8
        @(negedge bit_clk); bit_rst = 1'b1;
        repeat (2) @(negedge bit_clk);
        chk("R8 ser low after reset", {15'b0, ser_out}, 16'h0);
        chk("R8 cclk low after reset", {15'b0, word_clk_out}, 16'h0);
        chk("R8 udf cleared", {15'b0, udf_flag}, 16'h0);
        @(negedge wr_clk); wr_rst = 1'b1;
        repeat (2) @(negedge wr_clk);
        chk("R8 ovf cleared", {15'b0, ovf_flag}, 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule